// File: doc/BRIEF.md
# Dual Cascadable Edge Event Counter

This block counts transitions on two external event inputs. Each input has its own 16-bit counter. A per-channel polarity bit chooses whether rising or falling edges are counted. Both inputs are asynchronous to the block clock, so each one passes through a two-flop synchronizer before edge detection.

A cascade bit joins the two counters into one 32-bit counter that is driven by input A. Counter A is the low half and counter B is the high half.

A host works through a small register port. It sets the control bits, presets either counter, and reads counts from holding registers. A 0-to-1 transition of the snapshot bit loads both holding registers in the same cycle, so the host always reads a coherent pair. The pair then stays frozen until the snapshot bit goes 0 and back to 1.

A change of polarity can itself look like an edge. For that reason, software sets the polarity first and presets the counters afterwards.

Top module: `evc_top`

## Requirements
- R1: After reset, the control register, both counters, both holding registers and `host_rdata` are all zero.
- R2: Control register layout at address 0:
  - bit 0 is the polarity of input A.
  - bit 1 is the polarity of input B.
  - bit 2 is the cascade enable.
  - bit 3 is the snapshot bit.
  - Reading address 0 returns these four bits in the low bits, with zeros above them.
- R3: When a channel's polarity is 0, each rising edge of its input adds one to its counter. Falling edges are not counted.
- R4: When a channel's polarity is 1, each falling edge of its input adds one to its counter. Rising edges are not counted.
- R5: With cascade off, the counters are independent. Counter A wraps from FFFFh to 0000h without touching counter B.
- R6: With cascade on, counter B adds one when counter A wraps from FFFFh to 0000h. Edges on input B are ignored.
- R7: A 0-to-1 transition of the snapshot bit copies both live counters into the holding registers in the same cycle. The holding registers then stay unchanged until the next 0-to-1 transition. Reading address 1 returns the holding register for A, and reading address 2 returns the holding register for B.
- R8: Writing address 1 presets counter A, and writing address 2 presets counter B. A preset wins over an edge that arrives in the same cycle; that edge is lost.
- R9: If a polarity bit is flipped while its input is held low, the channel counts exactly one spurious edge when the bit goes 0→1. It counts none when the bit goes 1→0.
- R10: The read port is registered. `host_rdata` shows the register selected by `host_addr` one clock edge after the address is presented.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a | input | 1 | Asynchronous event input A |
| evt_b | input | 1 | Asynchronous event input B |
| host_we | input | 1 | Write strobe for the register port |
| host_addr | input | 2 | Register select: 0 control, 1 count A, 2 count B |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |

## Verification
An input change made before clock edge k reaches the counter at edge k+2:
- edge k loads the first synchronizer stage;
- edge k+1 loads the second stage, and the edge pulse becomes valid;
- edge k+2 loads the counter.

A rise of the snapshot bit written at edge e loads the holding registers at edge e+1. A read address presented before an edge appears on `host_rdata` right after that edge.

The bench waits at least three edges after every input change before it starts a snapshot. It samples read data one time unit after the edge that registers it. For the preset-priority case, it lines the host write up with exactly edge k+2 of an input rise.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CNT_A = 2'd1;
  localparam logic [1:0] ADDR_CNT_B = 2'd2;

  typedef struct packed {
    logic snap;
    logic casc;
    logic pol_b;
    logic pol_a;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic pol,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              lvl;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], din};
  end

  // Polarity is folded into the level, so a falling input looks like a rise.
  assign lvl = sync_q[STAGES-1] ^ pol;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign pulse = lvl & ~prev_q;
endmodule

// File: rtl/evc_counters.sv
module evc_counters #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    inc,
  input  logic          casc,
  input  logic [1:0]    ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b
);
  logic carry;
  logic step_b;

  assign carry  = casc & inc[0] & ~ld[0] & (cnt_a == '1);
  assign step_b = casc ? carry : inc[1];

  always_ff @(posedge clk) begin
    if (rst)         cnt_a <= '0;
    else if (ld[0])  cnt_a <= ld_val;
    else if (inc[0]) cnt_a <= cnt_a + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_b <= '0;
    else if (ld[1])  cnt_b <= ld_val;
    else if (step_b) cnt_b <= cnt_b + 1'b1;
  end
endmodule

// File: rtl/evc_snapshot.sv
module evc_snapshot #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  output logic [CW-1:0] hold_a,
  output logic [CW-1:0] hold_b
);
  logic snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= 1'b0;
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      snap_q <= snap;
      if (snap && !snap_q) begin
        hold_a <= cnt_a;
        hold_b <= cnt_b;
      end
    end
  end
endmodule

// File: rtl/evc_top.sv
module evc_top #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_a,
  input  logic          evt_b,
  input  logic          host_we,
  input  logic [1:0]    host_addr,
  input  logic [CW-1:0] host_wdata,
  output logic [CW-1:0] host_rdata
);
  import evc_pkg::*;

  ctrl_t          ctrl_q;
  logic [1:0]     evt_in;
  logic [1:0]     pol;
  logic [1:0]     pulse;
  logic [1:0]     ld;
  logic [CW-1:0]  cnt_a, cnt_b, hold_a, hold_b;

  assign evt_in = {evt_b, evt_a};
  assign pol    = {ctrl_q.pol_b, ctrl_q.pol_a};

  always_ff @(posedge clk) begin
    if (rst)                                ctrl_q <= '0;
    else if (host_we && host_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(host_wdata[CTRL_W-1:0]);
  end

  assign ld[0] = host_we && (host_addr == ADDR_CNT_A);
  assign ld[1] = host_we && (host_addr == ADDR_CNT_B);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    evc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .din   (evt_in[ch]),
      .pol   (pol[ch]),
      .pulse (pulse[ch])
    );
  end

  evc_counters #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .inc    (pulse),
    .casc   (ctrl_q.casc),
    .ld     (ld),
    .ld_val (host_wdata),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b)
  );

  evc_snapshot #(.CW(CW)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .snap   (ctrl_q.snap),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .hold_a (hold_a),
    .hold_b (hold_b)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      unique case (host_addr)
        ADDR_CTRL:  host_rdata <= CW'(ctrl_q);
        ADDR_CNT_A: host_rdata <= hold_a;
        ADDR_CNT_B: host_rdata <= hold_b;
        default:    host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evc_check.sv
module evc_check #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          host_we,
  input logic [1:0]    host_addr,
  input logic [CW-1:0] host_wdata,
  input logic [CW-1:0] host_rdata,
  input logic [3:0]    ctrl,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] hold_a,
  input logic [CW-1:0] hold_b
);
  logic snap_d;
  logic snap_rise;

  always_ff @(posedge clk) begin
    if (rst) snap_d <= 1'b0;
    else     snap_d <= ctrl[3];
  end
  assign snap_rise = ctrl[3] & ~snap_d;

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !snap_rise |=> ($stable(hold_a) && $stable(hold_b)));  // R7

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
    snap_rise |=> (hold_a == $past(cnt_a) && hold_b == $past(cnt_b)));  // R7

  AST_PRESET_WINS: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 2'd1) |=> cnt_a == $past(host_wdata));  // R8

  AST_A_STEP: assert property (@(posedge clk) disable iff (rst)
    !(host_we && host_addr == 2'd1) |=>
      (cnt_a == $past(cnt_a) || cnt_a == CW'($past(cnt_a) + 1'b1)));  // R3

  AST_B_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && !(host_we && host_addr == 2'd2) && cnt_a != '1) |=> $stable(cnt_b));  // R6

  AST_CARRY: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] && !host_we && cnt_a == '1) |=>
      ((cnt_a == '0) == (cnt_b == CW'($past(cnt_b) + 1'b1))));  // R6

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
    (host_addr == 2'd0) |=> host_rdata == CW'($past(ctrl)));  // R10
endmodule

bind evc_top evc_check #(.CW(CW)) u_evc_check (
  .clk        (clk),
  .rst        (rst),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .ctrl       (ctrl_q),
  .cnt_a      (cnt_a),
  .cnt_b      (cnt_b),
  .hold_a     (hold_a),
  .hold_b     (hold_b)
);

// File: tb/evc_top_test.sv
module evc_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_a = 1'b0;
  logic        evt_b = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evc_top uut (
    .clk(clk), .rst(rst), .evt_a(evt_a), .evt_b(evt_b),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(posedge clk); #1;
    d = host_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ctrl bits: 0 pol A, 1 pol B, 2 cascade, 3 snapshot
  task automatic snap_read(input logic [2:0] cfg, output logic [15:0] a, output logic [15:0] b);
    wr(2'd0, {12'd0, 1'b0, cfg});
    wr(2'd0, {12'd0, 1'b1, cfg});
    idle(2);
    rd(2'd1, a);
    rd(2'd2, b);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    if (ch == 0) evt_a = 1'b1; else evt_b = 1'b1;
    idle(3);
    if (ch == 0) evt_a = 1'b0; else evt_b = 1'b0;
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, ha, hb;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check("R1 rdata", host_rdata, 16'h0);
    rd(2'd0, v); check("R1 ctrl", v, 16'h0);
    rd(2'd1, v); check("R1 holdA", v, 16'h0);
    rd(2'd2, v); check("R1 holdB", v, 16'h0);

    // R2/R10 control readback
    wr(2'd0, 16'hFFF6);
    rd(2'd0, v); check("R2 ctrl read", v, 16'h0006);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); check("R10 ctrl read", v, 16'h0000);

    // R3/R4 sweep: channel x polarity x pulse count
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < 2; p++) begin
        for (int n = 0; n < 6; n++) begin
          logic [2:0] cfg;
          cfg = (ch == 0) ? {2'b00, p[0]} : {1'b0, p[0], 1'b0};
          wr(2'd0, {13'd0, cfg});
          idle(4);
          wr(2'd1, 16'h0);
          wr(2'd2, 16'h0);
          for (int k = 0; k < n; k++) pulse(ch);
          snap_read(cfg, ha, hb);
          if (ch == 0) begin
            check(p ? "R4 count A" : "R3 count A", ha, 16'(n));
            check("R5 B untouched", hb, 16'h0);
          end else begin
            check("R5 A untouched", ha, 16'h0);
            check(p ? "R4 count B" : "R3 count B", hb, 16'(n));
          end
        end
      end
    end

    // R9 spurious count on polarity flip with input low
    wr(2'd0, 16'h0000); idle(4);
    wr(2'd1, 16'h0); wr(2'd2, 16'h0);
    wr(2'd0, 16'h0001); idle(4);
    snap_read(3'b001, ha, hb);
    check("R9 0->1 flip counts one", ha, 16'h1);
    wr(2'd0, 16'h0000); idle(4);
    snap_read(3'b000, ha, hb);
    check("R9 1->0 flip counts none", ha, 16'h1);

    // R5 independent wrap
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0010);
    pulse(0);
    snap_read(3'b000, ha, hb);
    check("R5 wrap A", ha, 16'h0000);
    check("R5 no carry", hb, 16'h0010);

    // R6 cascade carry and B ignored
    wr(2'd0, 16'h0004); idle(4);
    wr(2'd1, 16'hFFFE); wr(2'd2, 16'h1234);
    for (int k = 0; k < 3; k++) pulse(0);
    pulse(1); pulse(1);
    snap_read(3'b100, ha, hb);
    check("R6 low half", ha, 16'h0001);
    check("R6 high half", hb, 16'h1235);

    // R7 hold frozen without a new rise
    pulse(0);
    rd(2'd1, v); check("R7 hold A frozen", v, 16'h0001);
    rd(2'd2, v); check("R7 hold B frozen", v, 16'h1235);
    wr(2'd0, 16'h000C); idle(2);
    rd(2'd1, v); check("R7 no rise no load", v, 16'h0001);
    snap_read(3'b100, ha, hb);
    check("R7 new snapshot", ha, 16'h0002);

    // R8 preset wins over a simultaneous edge (edge reaches counter at k+2)
    wr(2'd0, 16'h0000); idle(4);
    wr(2'd1, 16'h0050);
    @(negedge clk); evt_a = 1'b1;   // before edge k
    @(negedge clk);                  // after k
    @(negedge clk);                  // after k+1
    host_we = 1'b1; host_addr = 2'd1; host_wdata = 16'h00AA;
    @(negedge clk);                  // after k+2
    host_we = 1'b0;
    idle(3); evt_a = 1'b0; idle(4);
    snap_read(3'b000, ha, hb);
    check("R8 preset wins", ha, 16'h00AA);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule